// File: doc/BRIEF.md
# Serial NOR Flash Operation Sequencer

This block runs whole serial NOR flash operations on behalf of a host. The host presents one request: an operation select, a 24-bit flash address and one data byte. The block then drives the SPI pins itself. It frames each command with chip select, sends the command byte, sends the address bytes most significant first, and then either sends the data byte or clocks one byte back in.

Program and erase each start an internal write cycle in the flash. After either one, the sequencer keeps issuing status reads until the flash reports that it is idle, and only then signals completion. A write-enable request is followed automatically by one status read, so the host can see whether the write-enable latch was set.

The host waits for the single-cycle `done` pulse and then takes `rd_data`. While `busy` is high, any new request is dropped.

Top module: `flash_op_seq`

## Requirements
- R1: While reset is high and after it is released, `spi_cs_n` is 1, `spi_sck` is 0, and `busy`, `done` and `rd_data` are 0.
- R2: `req_op` selects the operation and its command byte: 0 = write enable (0x06), 1 = status read (0x05), 2 = program (0x02), 3 = read (0x03), 4 = sector erase (0x20). Codes 5 to 7 are dropped: no SPI activity takes place and `busy` stays low.
- R3: `spi_cs_n` stays low for every byte of a command and goes high between commands. Where a command carries an address, the three address bytes follow the command byte, most significant byte first.
- R4: SPI mode 0 is used. `spi_sck` rests low, `spi_mosi` changes only while `spi_sck` is low, and `spi_miso` is sampled on the rising edge of `spi_sck`.
- R5: Write enable sends a one-byte 0x06 command and then a two-byte status read. `rd_data` returns that status byte, which is 0x02 when the write-enable latch (bit 1) is set.
- R6: Status read sends 0x05 followed by one dummy byte. `rd_data` returns the byte clocked in during the dummy byte.
- R7: Program sends a five-byte command (0x02, address, data). It then repeats two-byte status reads until bit 0 (busy) of the status reads 0. `rd_data` is left unchanged.
- R8: Read sends 0x03, the address and one dummy byte, and returns the byte clocked in during the dummy byte on `rd_data`. A programmed byte reads back unchanged.
- R9: Erase sends a four-byte command (0x20 and the address) and then polls status as in R7. Afterwards, reads inside the erased sector return 0xFF, and sectors not erased keep their contents.
- R10: `busy` rises in the cycle after a request is accepted. `done` is a one-cycle pulse, and `busy` falls in the same cycle that `done` is high.
- R11: A request presented while `busy` is high is dropped. It causes no command and does not change the flash state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 3 | Operation select (see R2) |
| req_addr | input | 24 | Flash byte address |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte returned by read, status read or write enable |
| spi_sck | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest case to reach is the status-poll loop taking several rounds. To drive it, the bench contains a flash model that keeps the busy bit set for a fixed number of status reads after a program (three) or an erase (five). The bench then checks the exact list of commands seen on the wire, including the number of polls. Requests that arrive mid-operation are injected while a read is still shifting bits. The bench then shows that nothing happened by checking three things: no extra command appeared, the read result is intact, and a later status read shows the write-enable latch still clear.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_WREN  = 3'd0,
    OP_RDSR  = 3'd1,
    OP_PROG  = 3'd2,
    OP_READ  = 3'd3,
    OP_ERASE = 3'd4
  } host_op_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_BYTE, PH_WAIT, PH_GAP
  } phase_e;

  // MAIN: the requested command; WEL: status check after write enable;
  // POLL: status read while the flash is busy
  typedef enum logic [1:0] {
    FR_MAIN, FR_WEL, FR_POLL
  } frame_e;

  localparam logic [7:0] CMD_WREN  = 8'h06;
  localparam logic [7:0] CMD_RDSR  = 8'h05;
  localparam logic [7:0] CMD_PROG  = 8'h02;
  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CMD_ERASE = 8'h20;

  function automatic logic [7:0] op_cmd(host_op_e op);
    case (op)
      OP_WREN:  return CMD_WREN;
      OP_RDSR:  return CMD_RDSR;
      OP_PROG:  return CMD_PROG;
      OP_READ:  return CMD_READ;
      default:  return CMD_ERASE;
    endcase
  endfunction
endpackage

// File: rtl/spi_byte_shifter.sv
`timescale 1ns/1ps
module spi_byte_shifter #(
  parameter int HALF_DIV = 2,
  parameter int BW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [BW-1:0] tx_byte,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output logic          done,
  output logic [BW-1:0] rx_byte
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int NW = $clog2(BW);

  logic          active;
  logic [CW-1:0] hcnt;
  logic [NW-1:0] nbit;
  logic [BW-1:0] tx_sh;
  logic [BW-1:0] rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      hcnt    <= '0;
      nbit    <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      done    <= 1'b0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          tx_sh  <= tx_byte;
          mosi   <= tx_byte[BW-1];
          hcnt   <= '0;
          nbit   <= '0;
          sck    <= 1'b0;
        end
      end else if (hcnt == CW'(HALF_DIV - 1)) begin
        hcnt <= '0;
        if (!sck) begin
          sck   <= 1'b1;                        // rising edge: capture
          rx_sh <= {rx_sh[BW-2:0], miso};
        end else begin
          sck <= 1'b0;                          // falling edge: launch
          if (nbit == NW'(BW - 1)) begin
            active  <= 1'b0;
            done    <= 1'b1;
            rx_byte <= rx_sh;
          end else begin
            nbit  <= nbit + 1'b1;
            tx_sh <= {tx_sh[BW-2:0], 1'b0};
            mosi  <= tx_sh[BW-2];
          end
        end
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_frame_mux.sv
`timescale 1ns/1ps
module flash_frame_mux
  import flash_seq_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int IW        = $clog2(ADDR_BYTES + 3)
) (
  input  frame_e            kind,
  input  host_op_e          op,
  input  logic [IW-1:0]     idx,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic [7:0]        byte_o,
  output logic [IW-1:0]     len_o
);
  logic [ADDR_W-1:0] addr_sh;

  always_comb begin
    addr_sh = addr >> (8 * (ADDR_BYTES - int'(idx)));
    byte_o  = 8'h00;
    len_o   = IW'(1);
    if (kind != FR_MAIN) begin
      len_o  = IW'(2);
      byte_o = (idx == '0) ? CMD_RDSR : 8'h00;
    end else begin
      case (op)
        OP_WREN:          len_o = IW'(1);
        OP_RDSR:          len_o = IW'(2);
        OP_PROG, OP_READ: len_o = IW'(ADDR_BYTES + 2);
        default:          len_o = IW'(ADDR_BYTES + 1);
      endcase
      if (idx == '0)
        byte_o = op_cmd(op);
      else if (int'(idx) <= ADDR_BYTES)
        byte_o = addr_sh[7:0];
      else
        byte_o = (op == OP_PROG) ? data : 8'h00;
    end
  end
endmodule

// File: rtl/flash_op_seq.sv
`timescale 1ns/1ps
module flash_op_seq
  import flash_seq_pkg::*;
#(
  parameter int SCK_HALF   = 2,
  parameter int CS_GAP     = 4,
  parameter int ADDR_BYTES = 3,
  localparam int ADDR_W    = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rd_data,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int IW = $clog2(ADDR_BYTES + 3);
  localparam int GW = $clog2(CS_GAP + 1);

  phase_e            ph;
  frame_e            kind;
  host_op_e          op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [IW-1:0]     idx;
  logic [GW-1:0]     wcnt;
  logic              shf_start;
  logic              shf_done;
  logic [7:0]        shf_rx;
  logic [7:0]        rx_last;
  logic [7:0]        fr_byte;
  logic [IW-1:0]     fr_len;

  flash_frame_mux #(.ADDR_BYTES(ADDR_BYTES)) u_mux (
    .kind(kind), .op(op_q), .idx(idx), .addr(addr_q), .data(data_q),
    .byte_o(fr_byte), .len_o(fr_len)
  );

  spi_byte_shifter #(.HALF_DIV(SCK_HALF), .BW(BYTE_W)) u_shf (
    .clk(clk), .rst(rst), .start(shf_start), .tx_byte(fr_byte),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
    .done(shf_done), .rx_byte(shf_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      kind      <= FR_MAIN;
      op_q      <= OP_WREN;
      addr_q    <= '0;
      data_q    <= '0;
      idx       <= '0;
      wcnt      <= '0;
      shf_start <= 1'b0;
      rx_last   <= '0;
      spi_cs_n  <= 1'b1;
      busy      <= 1'b0;
      done      <= 1'b0;
      rd_data   <= '0;
    end else begin
      done      <= 1'b0;
      shf_start <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (req_valid && req_op <= 3'd4) begin
            op_q     <= host_op_e'(req_op);
            addr_q   <= req_addr;
            data_q   <= req_data;
            kind     <= FR_MAIN;
            idx      <= '0;
            wcnt     <= '0;
            spi_cs_n <= 1'b0;
            busy     <= 1'b1;
            ph       <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (wcnt == GW'(CS_GAP - 1)) begin
            wcnt <= '0;
            ph   <= PH_BYTE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        PH_BYTE: begin
          shf_start <= 1'b1;
          ph        <= PH_WAIT;
        end
        PH_WAIT: begin
          if (shf_done) begin
            if (idx == fr_len - IW'(1)) begin
              spi_cs_n <= 1'b1;
              rx_last  <= shf_rx;
              ph       <= PH_GAP;
            end else begin
              idx <= idx + 1'b1;
              ph  <= PH_BYTE;
            end
          end
        end
        PH_GAP: begin
          if (wcnt == GW'(CS_GAP - 1)) begin
            wcnt <= '0;
            idx  <= '0;
            if (kind == FR_MAIN && op_q == OP_WREN) begin
              kind     <= FR_WEL;
              spi_cs_n <= 1'b0;
              ph       <= PH_SETUP;
            end else if (kind == FR_MAIN && (op_q == OP_PROG || op_q == OP_ERASE)) begin
              kind     <= FR_POLL;
              spi_cs_n <= 1'b0;
              ph       <= PH_SETUP;
            end else if (kind == FR_POLL && rx_last[0]) begin
              spi_cs_n <= 1'b0;
              ph       <= PH_SETUP;
            end else begin
              done <= 1'b1;
              busy <= 1'b0;
              ph   <= PH_IDLE;
              if (kind == FR_WEL || (kind == FR_MAIN && (op_q == OP_RDSR || op_q == OP_READ)))
                rd_data <= rx_last;
            end
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_op_seq_chk.sv
`timescale 1ns/1ps
module flash_op_seq_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_mosi
);
  // R3
  cs_high_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> spi_cs_n);
  // R4
  sck_low_outside_frame_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);
  // R4
  mosi_stable_high_chk: assert property (@(posedge clk) disable iff (rst)
    spi_sck |-> $stable(spi_mosi));
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

bind flash_op_seq flash_op_seq_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
);

// File: tb/flash_op_seq_tb.sv
`timescale 1ns/1ps
module flash_op_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic        busy, done, spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;

  always #2.5 clk = ~clk;

  flash_op_seq u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
    .rd_data(rd_data), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // ---------------- behavioural flash model ----------------
  logic [7:0] fmem [int];
  logic       wel = 1'b0;
  int         wip = 0;
  int         bits = 0;
  logic [7:0] rsh = '0, cur_op = '0, f_data = '0, nxt_out = '0, out_sh = '0;
  int         f_addr = 0;
  logic [7:0] frame_ops[$];
  int         frame_bytes[$];
  int         frame_addrs[$];

  function automatic logic [7:0] mem_rd(int a);
    return fmem.exists(a) ? fmem[a] : 8'hFF;
  endfunction

  always @(negedge spi_cs_n) begin
    bits = 0; f_addr = 0; nxt_out = 8'h00;
  end

  always @(posedge spi_sck) if (spi_cs_n === 1'b0) begin
    rsh = {rsh[6:0], spi_mosi};
    bits++;
    if (bits % 8 == 0) begin
      case (bits / 8)
        1: begin
          cur_op = rsh;
          if (rsh == 8'h05) nxt_out = {6'b0, wel, wip > 0};
        end
        2, 3, 4: begin
          f_addr = (f_addr << 8) | int'(rsh);
          if (bits == 32 && cur_op == 8'h03) nxt_out = mem_rd(f_addr);
        end
        5: f_data = rsh;
        default: ;
      endcase
    end
  end

  always @(negedge spi_sck) if (spi_cs_n === 1'b0) begin
    if (bits % 8 == 0) begin
      spi_miso = nxt_out[7]; out_sh = nxt_out << 1;
    end else begin
      spi_miso = out_sh[7]; out_sh = out_sh << 1;
    end
  end

  always @(posedge spi_cs_n) if (bits > 0) begin
    if (bits % 8 != 0) begin
      errors++;
      $display("FAIL R3 partial byte in frame: bits=%0d expected multiple of 8", bits);
    end
    frame_ops.push_back(cur_op);
    frame_bytes.push_back(bits / 8);
    frame_addrs.push_back(f_addr);
    case (cur_op)
      8'h06: wel = 1'b1;
      8'h05: if (wip > 0) wip--;
      8'h02: if (wel && bits == 40 && wip == 0) begin
        fmem[f_addr] = mem_rd(f_addr) & f_data; wel = 1'b0; wip = 3;
      end
      8'h20: if (wel && bits == 32 && wip == 0) begin
        for (int k = f_addr & ~32'hFFF; k < (f_addr & ~32'hFFF) + 4096; k++)
          if (fmem.exists(k)) fmem.delete(k);
        wel = 1'b0; wip = 5;
      end
      default: ;
    endcase
    bits = 0;
  end

  // ---------------- per-clock reference of busy / done ----------------
  logic prev_busy = 1'b0;
  logic exp_busy  = 1'b0;
  always @(posedge clk) begin
    #1;
    if (rst) begin
      prev_busy = 1'b0; exp_busy = 1'b0;
    end else begin
      if (req_valid && !prev_busy && req_op <= 3'd4) exp_busy = 1'b1;
      else if (done) exp_busy = 1'b0;
      checks++;
      if (busy !== exp_busy) begin
        errors++;
        $display("FAIL R10 busy=%0b expected %0b at %0t", busy, exp_busy, $time);
      end
      if (done) begin
        done_cnt++;
        if (!prev_busy) begin
          errors++;
          $display("FAIL R10 done while idle: prev_busy=%0b expected 1", prev_busy);
        end
      end
      if (spi_cs_n && spi_sck) begin
        errors++;
        $display("FAIL R4 sck=%0b with cs_n high, expected 0", spi_sck);
      end
      prev_busy = busy;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    frame_ops.delete(); frame_bytes.delete(); frame_addrs.delete();
  endtask

  task automatic do_op(input logic [2:0] op, input logic [23:0] a, input logic [7:0] d);
    int start_cnt;
    clear_log();
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    start_cnt = done_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    while (done_cnt == start_cnt) @(negedge clk);
  endtask

  // first frame op0/nb0, then (n-1) two-byte status reads
  task automatic chk_frames(string tag, int n, logic [7:0] op0, int nb0);
    check({tag, " frame count"}, frame_ops.size(), n);
    if (frame_ops.size() == n && n > 0) begin
      check({tag, " opcode"}, frame_ops[0], op0);
      check({tag, " byte count"}, frame_bytes[0], nb0);
      for (int i = 1; i < n; i++) begin
        check({tag, " poll opcode"}, frame_ops[i], 8'h05);
        check({tag, " poll bytes"}, frame_bytes[i], 2);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: run incomplete, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 cs_n", spi_cs_n, 1); check("R1 sck", spi_sck, 0);
    check("R1 busy", busy, 0); check("R1 rd_data", rd_data, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 idle cs_n", spi_cs_n, 1); check("R1 done", done, 0);

    // R6 status read with latch clear
    do_op(3'd1, 24'h0, 8'h0);
    check("R6 status", rd_data, 8'h00);
    chk_frames("R6", 1, 8'h05, 2);

    // R5 write enable then status
    do_op(3'd0, 24'h0, 8'h0);
    check("R5 wel status", rd_data, 8'h02);
    check("R5 frames", frame_ops.size(), 2);
    if (frame_ops.size() == 2) begin
      check("R5 first opcode", frame_ops[0], 8'h06);
      check("R5 first bytes", frame_bytes[0], 1);
      check("R5 second opcode", frame_ops[1], 8'h05);
    end

    // R7 program 0x22 at 0x000001: 3 busy polls + 1 idle poll
    do_op(3'd2, 24'h000001, 8'h22);
    chk_frames("R7", 5, 8'h02, 5);
    if (frame_addrs.size() > 0) check("R3 prog addr", frame_addrs[0], 32'h1);
    check("R7 rd_data untouched", rd_data, 8'h02);
    do_op(3'd1, 24'h0, 8'h0);
    check("R7 status after prog", rd_data, 8'h00);

    // R8 read back
    do_op(3'd3, 24'h000001, 8'h0);
    check("R8 readback", rd_data, 8'h22);
    chk_frames("R8", 1, 8'h03, 5);

    // R3 address order with distinct bytes
    do_op(3'd0, 24'h0, 8'h0);
    do_op(3'd2, 24'hABCDEF, 8'hA5);
    if (frame_addrs.size() > 0) check("R3 msb-first addr", frame_addrs[0], 32'hABCDEF);
    do_op(3'd3, 24'hABCDEF, 8'h0);
    check("R8 readback A5", rd_data, 8'hA5);
    do_op(3'd3, 24'h123456, 8'h0);
    check("R8 blank read", rd_data, 8'hFF);

    // R9 erase sector 0: 5 busy polls + 1 idle poll
    do_op(3'd0, 24'h0, 8'h0);
    do_op(3'd4, 24'h000010, 8'h0);
    chk_frames("R9", 7, 8'h20, 4);
    do_op(3'd3, 24'h000001, 8'h0);
    check("R9 erased reads FF", rd_data, 8'hFF);
    do_op(3'd3, 24'hABCDEF, 8'h0);
    check("R9 other sector kept", rd_data, 8'hA5);

    // R11 request during busy is dropped
    begin
      int start_cnt;
      clear_log();
      @(negedge clk);
      req_valid = 1'b1; req_op = 3'd3; req_addr = 24'hABCDEF;
      start_cnt = done_cnt;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (10) @(negedge clk);
      req_valid = 1'b1; req_op = 3'd0;
      @(negedge clk);
      req_valid = 1'b0;
      while (done_cnt == start_cnt) @(negedge clk);
      check("R11 read intact", rd_data, 8'hA5);
      repeat (60) @(negedge clk);
      chk_frames("R11", 1, 8'h03, 5);
      check("R11 busy low", busy, 0);
    end
    do_op(3'd1, 24'h0, 8'h0);
    check("R11 latch not set", rd_data, 8'h00);

    // R2 invalid codes dropped
    clear_log();
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd5;
    @(negedge clk);
    req_op = 3'd7;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (30) @(negedge clk);
    check("R2 invalid no frames", frame_ops.size(), 0);
    check("R2 invalid busy", busy, 0);
    check("R2 invalid cs_n", spi_cs_n, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule